// File: doc/BRIEF.md
# Interlocked Asynchronous Read Link

This block holds both ends of a read transfer that crosses between two unrelated clock domains over a shared set of lines. There is one multiplexed address/data bus and three control lines: a read request, an acknowledge and a data-ready strobe. The requester end takes a read command on a valid/ready stream, puts the address on the bus and raises the request. The responder end captures that address, waits a programmable access latency and returns the word over the same bus. Every control edge waits for the matching edge from the far side. No part of the exchange depends on the ratio between the two clocks.

Each end passes the control lines it receives through a two-flop synchroniser before acting on them. The acknowledge line carries two pulses in each transfer. The responder raises the first to accept the address, and the requester raises the second to confirm it has the data. The visible line is the OR of the two contributions, and each end watches only the contribution of the other end. The responder reads from an internal word array. At reset it fills that array with a fixed pattern computed from the word index.

Command stream rules: a command is accepted on a requester clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while no transfer is in flight and no result is waiting. Result stream rules: `rd_valid` rises once the transfer has fully closed. `rd_data` then stays constant until a requester clock edge where `rd_ready` is high. A new command can only be accepted after that edge.

Top module: `hs_read_link`

## Requirements
- R1: After reset, `cmd_ready` is 1, `rd_valid` is 0, the request, acknowledge and data-ready lines are 0, and the bus reads 0.
- R2: While the request line is high, the requester drives the bus, and the bus holds the command address zero-extended to the bus width.
- R3: The acknowledge line falls after the address phase only while the request line is already low. The requester never drives the bus while its request is low.
- R4: The data-ready line rises exactly `rsp_latency`+1 responder clock cycles after the acknowledge line falls at the end of the address phase.
- R5: While data ready is high, the responder drives the bus with word `((a*16'h09D1) mod 2^16) ^ 16'h5A3C`, where `a` is the address. `rd_data` returns the same value.
- R6: Data ready falls only while the acknowledge line is high (the requester's receipt). The acknowledge line then falls, and all three control lines are low when the transfer ends.
- R7: The requester and the responder never drive the bus in the same cycle, and the bus reads 0 when neither drives it.
- R8: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high, `rd_data` is stable and `cmd_ready` is 0. A `cmd_valid` raised in that time is ignored and starts no request.
- R9: The lowest address (0) and the highest address (DEPTH-1) read back the correct words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_clk | input | 1 | Requester clock |
| req_rst_n | input | 1 | Requester reset, active low, asynchronous |
| rsp_clk | input | 1 | Responder clock |
| rsp_rst_n | input | 1 | Responder reset, active low, asynchronous |
| cmd_valid | input | 1 | Read command valid |
| cmd_ready | output | 1 | Requester can take a command |
| cmd_addr | input | AW (4) | Word address to read |
| rd_valid | output | 1 | Read result valid |
| rd_ready | input | 1 | Consumer takes the result |
| rd_data | output | DW (16) | Read result |
| rsp_latency | input | LW (4) | Responder access latency, in responder clocks |
| link_rreq | output | 1 | Read request line |
| link_ack | output | 1 | Acknowledge line (OR of both ends) |
| link_drdy | output | 1 | Data ready line |
| link_bus | output | DW (16) | Shared address/data bus value |

## Verification
The hardest states to reach are those where the two ends are held in a particular phase relation. One is a result left waiting under back-pressure while a new command knocks at a busy requester. The other is the zero-latency path, where data ready follows the acknowledge drop as early as the responder allows. The stimulus table sweeps latencies from 0 to 15 against result hold times from 0 to 5 cycles. The two clocks run at unrelated periods (5 ns and 7 ns), so their edges slide across every phase of the handshake. A monitor on the responder clock follows every line transition in turn, checks the order of the seven steps and counts the latency. One directed case holds `cmd_valid` high during a stalled result and then checks that no request leaks out.

// File: rtl/hs_read_link_pkg.sv
package hs_read_link_pkg;

  typedef enum logic [2:0] {
    RQ_IDLE,
    RQ_WAIT_ACK,
    RQ_WAIT_DATA,
    RQ_WAIT_DROP,
    RQ_HOLD
  } rq_state_t;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_WAIT_LOW,
    RS_ACCESS,
    RS_WAIT_ACK
  } rs_state_t;

endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hs_requester.sv
module hs_requester
  import hs_read_link_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  input  logic          far_ack,
  input  logic          far_drdy,
  input  logic [DW-1:0] bus_in,
  output logic          rreq,
  output logic          ack,
  output logic          oe,
  output logic [DW-1:0] drv
);
  localparam int PAD = DW - AW;

  rq_state_t     st;
  logic [AW-1:0] addr_q;
  logic          s_ack, s_drdy;

  hs_sync2 #(.W(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({far_drdy, far_ack}),
    .q    ({s_drdy, s_ack})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RQ_IDLE;
      addr_q  <= '0;
      rd_data <= '0;
      rreq    <= 1'b0;
      ack     <= 1'b0;
      oe      <= 1'b0;
    end else begin
      case (st)
        RQ_IDLE: if (cmd_valid) begin
          addr_q <= cmd_addr;
          oe     <= 1'b1;
          rreq   <= 1'b1;
          st     <= RQ_WAIT_ACK;
        end
        RQ_WAIT_ACK: if (s_ack) begin
          rreq <= 1'b0;
          oe   <= 1'b0;
          st   <= RQ_WAIT_DATA;
        end
        RQ_WAIT_DATA: if (s_drdy) begin
          rd_data <= bus_in;
          ack     <= 1'b1;
          st      <= RQ_WAIT_DROP;
        end
        RQ_WAIT_DROP: if (!s_drdy) begin
          ack <= 1'b0;
          st  <= RQ_HOLD;
        end
        RQ_HOLD: if (rd_ready) st <= RQ_IDLE;
        default: st <= RQ_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st == RQ_IDLE);
  assign rd_valid  = (st == RQ_HOLD);
  assign drv       = {{PAD{1'b0}}, addr_q};
endmodule

// File: rtl/hs_responder.sv
module hs_responder
  import hs_read_link_pkg::*;
#(
  parameter int          AW    = 4,
  parameter int          DW    = 16,
  parameter int          LW    = 4,
  parameter logic [15:0] MIX   = 16'h09D1,
  parameter logic [15:0] SEED  = 16'h5A3C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] latency,
  input  logic          far_rreq,
  input  logic          far_ack,
  input  logic [AW-1:0] addr_in,
  output logic          ack,
  output logic          drdy,
  output logic          oe,
  output logic [DW-1:0] drv
);
  localparam int DEPTH = 1 << AW;

  rs_state_t     st;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] cnt;
  logic [DW-1:0] mem [DEPTH];
  logic          s_rreq, s_ack;

  hs_sync2 #(.W(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({far_rreq, far_ack}),
    .q    ({s_rreq, s_ack})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= DW'(i * int'(MIX)) ^ DW'(SEED);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RS_IDLE;
      addr_q <= '0;
      cnt    <= '0;
      drv    <= '0;
      ack    <= 1'b0;
      drdy   <= 1'b0;
      oe     <= 1'b0;
    end else begin
      case (st)
        RS_IDLE: if (s_rreq) begin
          addr_q <= addr_in;
          ack    <= 1'b1;
          st     <= RS_WAIT_LOW;
        end
        RS_WAIT_LOW: if (!s_rreq) begin
          ack <= 1'b0;
          cnt <= latency;
          st  <= RS_ACCESS;
        end
        RS_ACCESS: begin
          if (cnt == '0) begin
            drv  <= mem[addr_q];
            oe   <= 1'b1;
            drdy <= 1'b1;
            st   <= RS_WAIT_ACK;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        RS_WAIT_ACK: if (s_ack) begin
          drdy <= 1'b0;
          oe   <= 1'b0;
          st   <= RS_IDLE;
        end
        default: st <= RS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hs_read_link.sv
module hs_read_link #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int LW = 4
) (
  input  logic          req_clk,
  input  logic          req_rst_n,
  input  logic          rsp_clk,
  input  logic          rsp_rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  input  logic [LW-1:0] rsp_latency,
  output logic          link_rreq,
  output logic          link_ack,
  output logic          link_drdy,
  output logic [DW-1:0] link_bus
);
  logic          rq_rreq, rq_ack, rq_oe;
  logic [DW-1:0] rq_drv;
  logic          rs_ack, rs_drdy, rs_oe;
  logic [DW-1:0] rs_drv;

  hs_requester #(.AW(AW), .DW(DW)) u_req (
    .clk      (req_clk),
    .rst_n    (req_rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_addr (cmd_addr),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .far_ack  (rs_ack),
    .far_drdy (rs_drdy),
    .bus_in   (link_bus),
    .rreq     (rq_rreq),
    .ack      (rq_ack),
    .oe       (rq_oe),
    .drv      (rq_drv)
  );

  hs_responder #(.AW(AW), .DW(DW), .LW(LW)) u_rsp (
    .clk     (rsp_clk),
    .rst_n   (rsp_rst_n),
    .latency (rsp_latency),
    .far_rreq(rq_rreq),
    .far_ack (rq_ack),
    .addr_in (link_bus[AW-1:0]),
    .ack     (rs_ack),
    .drdy    (rs_drdy),
    .oe      (rs_oe),
    .drv     (rs_drv)
  );

  assign link_bus  = rq_oe ? rq_drv : (rs_oe ? rs_drv : '0);
  assign link_rreq = rq_rreq;
  assign link_ack  = rq_ack | rs_ack;
  assign link_drdy = rs_drdy;
endmodule

// File: rtl/hs_read_link_chk.sv
module hs_read_link_chk #(
  parameter int DW = 16
) (
  input logic          req_clk,
  input logic          req_rst_n,
  input logic          rsp_clk,
  input logic          rsp_rst_n,
  input logic          rq_oe,
  input logic          rq_rreq,
  input logic          rq_ack,
  input logic          rs_oe,
  input logic          rs_ack,
  input logic          rs_drdy,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data
);
  p_no_clash_r7: assert property (@(posedge rsp_clk) disable iff (!rsp_rst_n)
    !(rq_oe && rs_oe));

  p_addr_driven_r2: assert property (@(posedge req_clk) disable iff (!req_rst_n)
    rq_rreq |-> rq_oe);

  p_ack_apart_r3: assert property (@(posedge rsp_clk) disable iff (!rsp_rst_n)
    rs_ack |-> !rs_drdy);

  p_data_driven_r5: assert property (@(posedge rsp_clk) disable iff (!rsp_rst_n)
    rs_drdy |-> rs_oe);

  p_receipt_apart_r6: assert property (@(posedge req_clk) disable iff (!req_rst_n)
    rq_ack |-> !rq_rreq);

  p_result_hold_r8: assert property (@(posedge req_clk) disable iff (!req_rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

bind hs_read_link hs_read_link_chk #(.DW(DW)) u_chk (
  .req_clk  (req_clk),
  .req_rst_n(req_rst_n),
  .rsp_clk  (rsp_clk),
  .rsp_rst_n(rsp_rst_n),
  .rq_oe    (rq_oe),
  .rq_rreq  (rq_rreq),
  .rq_ack   (rq_ack),
  .rs_oe    (rs_oe),
  .rs_ack   (rs_ack),
  .rs_drdy  (rs_drdy),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data)
);

// File: tb/sim_hs_read_link.sv
module sim_hs_read_link;
  logic        req_clk = 0, rsp_clk = 0;
  logic        req_rst_n = 0, rsp_rst_n = 0;
  logic        cmd_valid = 0, rd_ready = 0;
  logic [3:0]  cmd_addr = 0, rsp_latency = 0;
  logic        cmd_ready, rd_valid, link_rreq, link_ack, link_drdy;
  logic [15:0] rd_data, link_bus;

  int n_tests = 0, n_fail = 0, n_done = 0;
  logic [3:0] exp_addr = 0;
  logic [3:0] exp_lat  = 0;

  always #2.5 req_clk = ~req_clk;
  always #3.5 rsp_clk = ~rsp_clk;

  hs_read_link u0 (.*);

  function automatic logic [15:0] word_of(input logic [3:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'h9D1;
    return t[15:0] ^ 16'h5A3C;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Responder-clock monitor following the handshake order.
  int   ph = 0, lat_cnt = 0;
  logic p_ack = 0, p_drdy = 0, p_rreq = 0;
  always @(negedge rsp_clk) begin
    if (req_rst_n && rsp_rst_n) begin
      case (ph)
        0: if (link_rreq && !p_rreq) begin
          check(link_bus == {12'd0, exp_addr}, "R2 address on bus", link_bus, exp_addr);
          ph = 1;
        end
        1: begin
          if (link_rreq)
            check(link_bus == {12'd0, exp_addr}, "R2 address held", link_bus, exp_addr);
          if (p_ack && !link_ack) begin
            check(!link_rreq, "R3 ack falls after request low", link_rreq, 0);
            lat_cnt = 0;
            ph = 2;
          end
        end
        2: begin
          lat_cnt++;
          if (link_drdy) begin
            check(lat_cnt == int'(exp_lat) + 1, "R4 latency", lat_cnt, exp_lat + 1);
            check(link_bus == word_of(exp_addr), "R5 data on bus", link_bus,
                  word_of(exp_addr));
            ph = 3;
          end
        end
        3: if (p_drdy && !link_drdy) begin
          check(link_ack, "R6 drdy falls under receipt ack", link_ack, 1);
          ph = 4;
        end
        4: if (!link_ack) begin
          check(!link_rreq && !link_drdy, "R6 lines low at end",
                {link_rreq, link_drdy}, 0);
          n_done++;
          ph = 0;
        end
        default: ph = 0;
      endcase
      p_ack = link_ack; p_drdy = link_drdy; p_rreq = link_rreq;
    end
  end

  task automatic transfer(input logic [3:0] a, input logic [3:0] lat,
                          input int hold, input logic poke);
    @(negedge req_clk);
    while (!cmd_ready) @(negedge req_clk);
    rsp_latency = lat; exp_lat = lat; exp_addr = a;
    cmd_addr = a; cmd_valid = 1;
    @(negedge req_clk);
    cmd_valid = 0;
    while (!rd_valid) @(negedge req_clk);
    for (int d = 0; d < hold; d++) begin
      if (poke) begin cmd_valid = 1; cmd_addr = ~a; end
      check(rd_valid && rd_data == word_of(a), "R8 result held", rd_data, word_of(a));
      check(!cmd_ready, "R8 busy under back-pressure", cmd_ready, 0);
      @(negedge req_clk);
    end
    check(rd_data == word_of(a), "R5 read word", rd_data, word_of(a));
    rd_ready = 1; cmd_valid = 0;
    @(negedge req_clk);
    rd_ready = 0;
    check(!rd_valid && cmd_ready, "R8 result consumed", {rd_valid, cmd_ready}, 1);
  endtask

  // addr, latency, hold cycles
  localparam logic [11:0] VEC [10] = '{
    {4'd0,  4'd0,  4'd0},
    {4'd15, 4'd0,  4'd2},
    {4'd5,  4'd3,  4'd0},
    {4'd10, 4'd15, 4'd1},
    {4'd1,  4'd1,  4'd5},
    {4'd7,  4'd7,  4'd0},
    {4'd12, 4'd2,  4'd3},
    {4'd3,  4'd9,  4'd0},
    {4'd14, 4'd0,  4'd4},
    {4'd8,  4'd4,  4'd1}
  };

  initial begin
    repeat (4) @(negedge req_clk);
    req_rst_n = 1; rsp_rst_n = 1;
    @(negedge req_clk);
    check(cmd_ready && !rd_valid, "R1 reset stream state", {cmd_ready, rd_valid}, 2);
    check(!link_rreq && !link_ack && !link_drdy, "R1 reset lines",
          {link_rreq, link_ack, link_drdy}, 0);
    check(link_bus == 0, "R1 R7 idle bus", link_bus, 0);

    foreach (VEC[i]) transfer(VEC[i][11:8], VEC[i][7:4], int'(VEC[i][3:0]), 1'b0);

    // R9 boundary addresses checked directly
    transfer(4'd0, 4'd6, 0, 1'b0);
    transfer(4'd15, 4'd6, 0, 1'b0);

    // R8: command raised while a result is stalled is ignored
    transfer(4'd9, 4'd2, 3, 1'b1);
    repeat (12) @(negedge req_clk);
    check(!link_rreq && cmd_ready, "R8 ignored command starts nothing",
          {link_rreq, cmd_ready}, 1);
    check(link_bus == 0, "R7 bus undriven after transfers", link_bus, 0);
    repeat (12) @(negedge req_clk);
    check(n_done == 13, "R6 all transfers closed", n_done, 13);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge req_clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule